// File: doc/BRIEF.md
# USB Function Interrupt Flag Register

This block collects interrupt causes for a USB device controller into one 8-bit flag word and pairs it with an 8-bit enable word. Four single-cycle event pulses come from the protocol engine: bus reset seen, endpoint 2 IN token with nothing to send, setup command accepted, and endpoint 0 OUT data accepted. Each pulse sets a sticky flag. Two more positions carry live FIFO status that software can read but not clear.

Software reads and writes both words through a small register port. Address 0 selects the flag word and address 1 selects the enable word. A sticky flag clears only when a 0 is written to its position. Writing 1 leaves it alone, so one flag can be cleared without disturbing the others. A single level interrupt request goes to the CPU. It is registered and is high whenever any enabled position of the flag word is 1.

Top module: `usbf_irq_flags`

## Requirements
- R1: After reset the sticky flags (bits 7, 5, 3, 2), the whole enable word and `irq` are all 0.
- R2: A one-cycle pulse sets its own flag bit: `ev_bus_reset` sets bit 7, `ev_ep2_in_nodata` sets bit 5, `ev_setup_ok` sets bit 3 and `ev_ep0_out_ok` sets bit 2. The bit is visible on a read in the cycle after the setting edge.
- R3: Writing the flag word (address 0) clears each sticky bit written as 0 and leaves unchanged each sticky bit written as 1.
- R4: Bit 6 of the flag word always equals `st_ep1_full`, and no write changes it.
- R5: Bit 4 of the flag word always equals `st_ep2_empty`, and no write changes it. With both transmit buffers free during and after reset, the flag word reads 8'h10.
- R6: When an event pulse and a write of 0 reach the same sticky bit in the same cycle, the bit ends up set.
- R7: Bits 1 and 0 of both words read as 0, whatever value is written to them.
- R8: Writing address 1 stores bits 7..2 of `reg_wdata` in the enable word, and reading address 1 returns them.
- R9: `irq` is a registered level. In the cycle after the edge at which any bit of (flag word AND enable word) is 1, `irq` is 1. It returns to 0 one cycle after every such bit is cleared or masked. The live status bits take part in this like any other bit.
- R10: `reg_rdata` follows `reg_addr` combinationally: 0 selects the flag word, 1 selects the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| ev_bus_reset | input | 1 | Pulse: bus reset detected |
| ev_ep2_in_nodata | input | 1 | Pulse: endpoint 2 IN token arrived with no transmit data ready |
| ev_setup_ok | input | 1 | Pulse: setup command received and acknowledged |
| ev_ep0_out_ok | input | 1 | Pulse: endpoint 0 OUT data stored and acknowledged |
| st_ep1_full | input | 1 | Level: endpoint 1 receive FIFO holds a valid packet |
| st_ep2_empty | input | 1 | Level: at least one endpoint 2 transmit buffer can accept data |
| reg_addr | input | 1 | Register select: 0 flag word, 1 enable word |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected word |
| irq | output | 1 | Interrupt request level to the CPU |

## Verification
Assertions check on every cycle that each sticky bit follows the set, clear and keep rules, including the case where an event and a clear collide. They also check that the enable word takes each write, that `irq` tracks the masked flags with one cycle of delay, and that the reserved bits stay 0. The bench scenarios are the only place where the exact bit position of each event, the readback values of the live status bits, the reset value of 8'h10, and the clear-one-by-writing-ones-elsewhere idiom are checked. Those depend on how the top assembles its words, not on any single submodule's rule.

// File: rtl/usbf_irq_pkg.sv
package usbf_irq_pkg;
  localparam int unsigned REG_W = 8;

  localparam int unsigned BIT_BUS_RST  = 7;
  localparam int unsigned BIT_EP1_FULL = 6;
  localparam int unsigned BIT_EP2_REQ  = 5;
  localparam int unsigned BIT_EP2_EMPT = 4;
  localparam int unsigned BIT_SETUP    = 3;
  localparam int unsigned BIT_EP0_OUT  = 2;

  localparam logic [REG_W-1:0] STICKY_MASK = (REG_W'(1) << BIT_BUS_RST)
                                           | (REG_W'(1) << BIT_EP2_REQ)
                                           | (REG_W'(1) << BIT_SETUP)
                                           | (REG_W'(1) << BIT_EP0_OUT);
  localparam logic [REG_W-1:0] STATUS_MASK = (REG_W'(1) << BIT_EP1_FULL)
                                           | (REG_W'(1) << BIT_EP2_EMPT);
  localparam logic [REG_W-1:0] LIVE_MASK   = STICKY_MASK | STATUS_MASK;

  typedef enum logic {
    SEL_FLAGS  = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/usbf_rst_sync.sv
module usbf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/usbf_flag_bank.sv
module usbf_flag_bank #(
  parameter int unsigned             W    = 8,
  parameter logic [W-1:0]            MASK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (MASK[i]) begin : g_sticky
      logic flag_q;
      logic flag_d;
      logic clr_hit;

      always_comb begin
        clr_hit = clr_we_i && !wdata_i[i];
        flag_d  = set_i[i] | (flag_q & ~clr_hit);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
      end

      assign q_o[i] = flag_q;

      AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        set_i[i] |=> q_o[i]);  // R6
      AST_ZERO_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we_i && !wdata_i[i] && !set_i[i]) |=> !q_o[i]);  // R3
      AST_ONE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        ((!clr_we_i || wdata_i[i]) && !set_i[i]) |=> (q_o[i] == $past(q_o[i])));  // R3
    end else begin : g_none
      assign q_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/usbf_en_reg.sv
module usbf_en_reg #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] en_q;
  logic [W-1:0] en_d;

  always_comb begin
    en_d = en_q;
    if (we_i) en_d = wdata_i & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= en_d;
  end

  assign q_o = en_q;

  AST_EN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (q_o == ($past(wdata_i) & MASK)));  // R8
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !we_i |=> $stable(q_o));  // R8
endmodule

// File: rtl/usbf_irq_gen.sv
module usbf_irq_gen #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  input  logic [W-1:0] en_i,
  output logic         irq_o
);
  logic irq_q;
  logic irq_d;

  always_comb begin
    irq_d = |(flags_i & en_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= irq_d;
  end

  assign irq_o = irq_q;

  AST_IRQ_RISES: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_i & en_i)) |=> irq_o);  // R9
  AST_IRQ_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(flags_i & en_i)) |=> !irq_o);  // R9
endmodule

// File: rtl/usbf_irq_flags.sv
module usbf_irq_flags
  import usbf_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev_bus_reset,
  input  logic             ev_ep2_in_nodata,
  input  logic             ev_setup_ok,
  input  logic             ev_ep0_out_ok,
  input  logic             st_ep1_full,
  input  logic             st_ep2_empty,
  input  logic             reg_addr,
  input  logic             reg_we,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic             rst_sync_n;
  logic [REG_W-1:0] set_vec;
  logic [REG_W-1:0] stat_vec;
  logic [REG_W-1:0] sticky_q;
  logic [REG_W-1:0] en_q;
  logic [REG_W-1:0] flag_word;
  logic             flag_we;
  logic             en_we;

  usbf_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  always_comb begin
    set_vec                = '0;
    set_vec[BIT_BUS_RST]   = ev_bus_reset;
    set_vec[BIT_EP2_REQ]   = ev_ep2_in_nodata;
    set_vec[BIT_SETUP]     = ev_setup_ok;
    set_vec[BIT_EP0_OUT]   = ev_ep0_out_ok;
    stat_vec               = '0;
    stat_vec[BIT_EP1_FULL] = st_ep1_full;
    stat_vec[BIT_EP2_EMPT] = st_ep2_empty;
    flag_we                = reg_we && (reg_sel_e'(reg_addr) == SEL_FLAGS);
    en_we                  = reg_we && (reg_sel_e'(reg_addr) == SEL_ENABLE);
  end

  usbf_flag_bank #(.W(REG_W), .MASK(STICKY_MASK)) u_flags (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_i    (set_vec),
    .clr_we_i (flag_we),
    .wdata_i  (reg_wdata),
    .q_o      (sticky_q)
  );

  usbf_en_reg #(.W(REG_W), .MASK(LIVE_MASK)) u_enable (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .we_i    (en_we),
    .wdata_i (reg_wdata),
    .q_o     (en_q)
  );

  always_comb begin
    flag_word = (sticky_q & STICKY_MASK) | (stat_vec & STATUS_MASK);
    reg_rdata = (reg_sel_e'(reg_addr) == SEL_ENABLE) ? en_q : flag_word;
  end

  usbf_irq_gen #(.W(REG_W)) u_irq (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .flags_i (flag_word),
    .en_i    (en_q),
    .irq_o   (irq)
  );

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    reg_rdata[1:0] == 2'b00);  // R7
  AST_EP1_MIRROR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (reg_addr == 1'b0) |-> (reg_rdata[BIT_EP1_FULL] == st_ep1_full));  // R4
endmodule

// File: tb/usbf_irq_flags_tb_top.sv
module usbf_irq_flags_tb_top;
  logic       clk;
  logic       rst_n;
  logic       ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok;
  logic       st_ep1_full, st_ep2_empty;
  logic       reg_addr, reg_we;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       irq;

  int n_checks = 0;
  int n_errors = 0;
  bit done     = 0;

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  usbf_irq_flags dut_i (
    .clk(clk), .rst_n(rst_n),
    .ev_bus_reset(ev_bus_reset), .ev_ep2_in_nodata(ev_ep2_in_nodata),
    .ev_setup_ok(ev_setup_ok), .ev_ep0_out_ok(ev_ep0_out_ok),
    .st_ep1_full(st_ep1_full), .st_ep2_empty(st_ep2_empty),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // monitor: samples 2 ns after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it  = sb_q.pop_front();
        act = it.is_irq ? {7'b0, irq} : reg_rdata;
        n_checks++;
        if (act !== it.exp) begin
          n_errors++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic expect_rd(input logic a, input logic [7:0] e, input string req);
    item_t it;
    reg_addr = a;
    it.is_irq = 1'b0; it.exp = e; it.req = req;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic expect_irq(input logic e, input string req);
    item_t it;
    it.is_irq = 1'b1; it.exp = {7'b0, e}; it.req = req;
    sb_q.push_back(it);
    tick();
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  // events: {bus_reset, ep2_in_nodata, setup_ok, ep0_out_ok}
  task automatic pulse(input logic [3:0] ev);
    {ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok} = ev;
    tick();
    {ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok} = 4'b0;
  endtask

  task automatic wr_pulse(input logic [7:0] d, input logic [3:0] ev);
    {ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok} = ev;
    reg_addr = 1'b0; reg_we = 1'b1; reg_wdata = d;
    tick();
    reg_we = 1'b0;
    {ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok} = 4'b0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    {ev_bus_reset, ev_ep2_in_nodata, ev_setup_ok, ev_ep0_out_ok} = 4'b0;
    st_ep1_full = 1'b0; st_ep2_empty = 1'b1;
    reg_addr = 1'b0; reg_we = 1'b0; reg_wdata = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (4) tick();

    // reset state
    expect_rd(1'b0, 8'h10, "R1/R5 reset flag word");
    expect_rd(1'b1, 8'h00, "R1 reset enable word");
    expect_irq(1'b0, "R1 reset irq");

    // event bit positions
    pulse(4'b1000); expect_rd(1'b0, 8'h90, "R2 bus reset bit7");
    pulse(4'b0100); expect_rd(1'b0, 8'hB0, "R2 ep2 request bit5");
    pulse(4'b0010); expect_rd(1'b0, 8'hB8, "R2 setup bit3");
    pulse(4'b0001); expect_rd(1'b0, 8'hBC, "R2 ep0 out bit2");
    expect_irq(1'b0, "R9 all masked");

    // clear semantics
    wr(1'b0, 8'hFF); expect_rd(1'b0, 8'hBC, "R3 write ones keeps");
    wr(1'b0, 8'h7F); expect_rd(1'b0, 8'h3C, "R3 clear bit7 only");
    st_ep1_full = 1'b1;
    expect_rd(1'b0, 8'h7C, "R4 ep1 full mirrors");
    wr(1'b0, 8'h00); expect_rd(1'b0, 8'h50, "R3/R4 clear all, status stays");
    st_ep1_full = 1'b0;
    expect_rd(1'b0, 8'h10, "R4 ep1 full drops");
    st_ep2_empty = 1'b0;
    expect_rd(1'b0, 8'h00, "R5 ep2 empty drops");
    wr(1'b0, 8'hFF); expect_rd(1'b0, 8'h00, "R7 flag write ones sets nothing");

    // enable register
    wr(1'b1, 8'hFF); expect_rd(1'b1, 8'hFC, "R7/R8 enable reserved bits");
    reg_addr = 1'b0; expect_rd(1'b0, 8'h00, "R10 addr0 selects flags");
    wr(1'b1, 8'h00); expect_rd(1'b1, 8'h00, "R8 enable cleared");

    // simultaneous set and clear
    wr_pulse(8'h00, 4'b0010); expect_rd(1'b0, 8'h08, "R6 set beats clear");
    wr(1'b0, 8'h00); expect_rd(1'b0, 8'h00, "R3 setup cleared");

    // interrupt timing
    wr(1'b1, 8'h04);
    pulse(4'b0001);
    expect_irq(1'b0, "R9 irq one cycle late");
    expect_irq(1'b1, "R9 irq raised");
    pulse(4'b1000);
    expect_irq(1'b1, "R9 irq held");
    wr(1'b1, 8'h00);
    expect_irq(1'b1, "R9 irq registered after mask");
    expect_irq(1'b0, "R9 irq masked");
    wr(1'b1, 8'h04);
    tick();
    expect_irq(1'b1, "R9 irq unmasked");
    wr(1'b0, 8'hFB);
    expect_irq(1'b1, "R9 irq registered after clear");
    expect_irq(1'b0, "R9 irq cleared");
    expect_rd(1'b0, 8'h80, "R3 bit7 kept by clear of bit2");
    wr(1'b1, 8'h40);
    st_ep1_full = 1'b1;
    tick();
    expect_irq(1'b1, "R9 status bit raises irq");
    st_ep1_full = 1'b0;
    tick();
    expect_irq(1'b0, "R9 status bit drop");

    tick();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule